// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits next to a simple in-order core and performs the register and program-counter work of entering an exception handler. The core raises a one-cycle request that carries the kind of exception, a store flag, the faulting virtual address and a coprocessor number. With it the core supplies the current and next program counters, the handler-relevant status bits (exception level, bootstrap vectors, interrupt vector select), the exception base address, and the current and exception shadow-set numbers.

One clock edge after a request, the block presents everything at once. It pulses a redirect strobe with the handler address and that address plus four. It drives the values the core writes into its exception state: the exception code, the delay-slot flag, the coprocessor field, the exception return address and the faulting address. It also drives the shadow-set numbers. Write-enable strobes tell the core which of these to commit.

After reset is released, the block issues one redirect to the boot vector and asks for coprocessor 1 to be marked usable.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While rst_n is low, redir_valid, exc_we, srs_we, badva_we, tlb_we and cu1_set are 0. On the first clock edge after release, redir_valid and cu1_set pulse for exactly one cycle, with redir_pc = 0xBFC00000 and redir_npc = 0xBFC00004.
- R2: The request kinds are encoded on req_kind as follows: interrupt 0, TLB modified 1, TLB refill 2, TLB invalid 3, address error 4, syscall 5, breakpoint 6, reserved instruction 7, coprocessor unusable 8, overflow 9, trap 10. The edge after req_valid produces these exc_code values: interrupt 0x0, TLB modified 0x1, TLB refill or invalid 0x2 for a load and 0x3 for a store, address error 0x4 for a load and 0x5 for a store, syscall 0x8, breakpoint 0x9, reserved instruction 0xA, coprocessor unusable 0xB, overflow 0xC, trap 0xD.
- R3: Every accepted request pulses exc_we and redir_valid together for one cycle, and exc_exl is 1 whatever the incoming exception level was.
- R4: When cur_pc + 4 differs from cur_npc, bd is 1 and epc = cur_pc - 4. Otherwise bd is 0 and epc = cur_pc.
- R5: The handler address is ebase + 0x180 by default. A TLB refill taken with the exception level clear uses ebase + 0x000. An interrupt with the interrupt vector select set uses ebase + 0x200. An overflow taken with bootstrap vectors set uses 0xBFC00200.
- R6: redir_npc always equals redir_pc + 4 when redir_valid is 1.
- R7: ce equals req_cop for the coprocessor-unusable kind and 0 for every other kind.
- R8: srs_we pulses with the exception only when both the exception level and the bootstrap bit were clear. It then sets srs_pss to the current set and srs_css to the exception set. Otherwise both outputs keep their values.
- R9: Address-error and TLB kinds pulse badva_we with badva = req_vaddr. Only the TLB kinds also pulse tlb_we with vpn2 = req_vaddr[31:13].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle exception request |
| req_kind | input | 4 | Exception kind (R2 encoding) |
| req_store | input | 1 | Faulting access was a store |
| req_vaddr | input | 32 | Faulting virtual address |
| req_cop | input | 2 | Offending coprocessor number |
| cur_pc | input | 32 | PC of the faulting instruction |
| cur_npc | input | 32 | Next PC |
| st_exl | input | 1 | Current exception level bit |
| st_bev | input | 1 | Bootstrap vector bit |
| cause_iv | input | 1 | Dedicated interrupt vector select |
| ebase | input | 32 | Exception base address |
| srs_cur | input | 4 | Current shadow set |
| srs_exc | input | 4 | Shadow set for exceptions |
| redir_valid | output | 1 | Redirect strobe |
| redir_pc | output | 32 | Handler PC |
| redir_npc | output | 32 | Handler PC + 4 |
| cu1_set | output | 1 | Reset request to mark coprocessor 1 usable |
| exc_we | output | 1 | Commit exception state |
| exc_exl | output | 1 | New exception level bit |
| exc_code | output | 5 | Exception code |
| bd | output | 1 | Delay-slot flag |
| ce | output | 2 | Coprocessor field |
| epc | output | 32 | Exception return address |
| badva_we | output | 1 | Commit faulting address |
| badva | output | 32 | Faulting address |
| tlb_we | output | 1 | Commit translation fields |
| vpn2 | output | 19 | Faulting virtual page pair number |
| srs_we | output | 1 | Commit shadow-set update |
| srs_pss | output | 4 | New previous shadow set |
| srs_css | output | 4 | New current shadow set |

## Verification
The assertions check the structural relations on every cycle. A strobe always follows a request, the handler pair is always four apart, the shadow-set and address write-enables never fire without an exception commit, the coprocessor field stays clear for other kinds, and the return address follows the delay-slot flag. Only the bench scenarios show that each kind yields its own code and vector under the different exception-level, bootstrap and interrupt-select settings, and that the shadow-set outputs keep their values when the swap is gated off.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [3:0] {
    K_INT = 4'd0, K_TLB_MOD = 4'd1, K_TLB_REFILL = 4'd2, K_TLB_INV = 4'd3,
    K_ADDR_ERR = 4'd4, K_SYSCALL = 4'd5, K_BREAK = 4'd6, K_RESV = 4'd7,
    K_COP_UNUSE = 4'd8, K_OVF = 4'd9, K_TRAP = 4'd10
  } exc_kind_e;

  localparam logic [31:0] BOOT_VEC     = 32'hBFC0_0000;
  localparam logic [31:0] BEV_OVF_VEC  = 32'hBFC0_0200;
  localparam logic [31:0] OFS_GENERAL  = 32'h0000_0180;
  localparam logic [31:0] OFS_INTVEC   = 32'h0000_0200;
  localparam logic [31:0] INSN_BYTES   = 32'd4;
endpackage

// File: rtl/exc_cause_enc.sv
module exc_cause_enc
  import exc_pkg::*;
#(
  parameter int CP_W = 2
) (
  input  logic [3:0]      kind,
  input  logic            is_store,
  input  logic [CP_W-1:0] cop,
  output logic [4:0]      code,
  output logic [CP_W-1:0] ce_val,
  output logic            bad_addr,
  output logic            is_tlb
);
  always_comb begin
    code     = 5'h00;
    bad_addr = 1'b0;
    is_tlb   = 1'b0;
    ce_val   = '0;
    case (exc_kind_e'(kind))
      K_INT:        code = 5'h00;
      K_TLB_MOD:    begin code = 5'h01; bad_addr = 1'b1; is_tlb = 1'b1; end
      K_TLB_REFILL,
      K_TLB_INV:    begin code = is_store ? 5'h03 : 5'h02; bad_addr = 1'b1; is_tlb = 1'b1; end
      K_ADDR_ERR:   begin code = is_store ? 5'h05 : 5'h04; bad_addr = 1'b1; end
      K_SYSCALL:    code = 5'h08;
      K_BREAK:      code = 5'h09;
      K_RESV:       code = 5'h0A;
      K_COP_UNUSE:  begin code = 5'h0B; ce_val = cop; end
      K_OVF:        code = 5'h0C;
      K_TRAP:       code = 5'h0D;
      default:      code = 5'h0A;
    endcase
  end
endmodule

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [3:0]    kind,
  input  logic          exl,
  input  logic          bev,
  input  logic          iv,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] vec
);
  always_comb begin
    vec = base + AW'(OFS_GENERAL);
    case (exc_kind_e'(kind))
      K_TLB_REFILL: if (!exl) vec = base;
      K_INT:        if (iv)   vec = base + AW'(OFS_INTVEC);
      K_OVF:        if (bev)  vec = AW'(BEV_OVF_VEC);
      default:      ;
    endcase
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SET_W = 4,
  parameter int CP_W  = 2,
  parameter int VPN_LSB = 13,
  localparam int VPN_W = AW - VPN_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       req_kind,
  input  logic             req_store,
  input  logic [AW-1:0]    req_vaddr,
  input  logic [CP_W-1:0]  req_cop,
  input  logic [AW-1:0]    cur_pc,
  input  logic [AW-1:0]    cur_npc,
  input  logic             st_exl,
  input  logic             st_bev,
  input  logic             cause_iv,
  input  logic [AW-1:0]    ebase,
  input  logic [SET_W-1:0] srs_cur,
  input  logic [SET_W-1:0] srs_exc,
  output logic             redir_valid,
  output logic [AW-1:0]    redir_pc,
  output logic [AW-1:0]    redir_npc,
  output logic             cu1_set,
  output logic             exc_we,
  output logic             exc_exl,
  output logic [4:0]       exc_code,
  output logic             bd,
  output logic [CP_W-1:0]  ce,
  output logic [AW-1:0]    epc,
  output logic             badva_we,
  output logic [AW-1:0]    badva,
  output logic             tlb_we,
  output logic [VPN_W-1:0] vpn2,
  output logic             srs_we,
  output logic [SET_W-1:0] srs_pss,
  output logic [SET_W-1:0] srs_css
);
  logic [4:0]      code_c;
  logic [CP_W-1:0] ce_c;
  logic            bad_c, tlb_c;
  logic [AW-1:0]   vec_c;

  exc_cause_enc #(.CP_W(CP_W)) u_enc (
    .kind(req_kind), .is_store(req_store), .cop(req_cop),
    .code(code_c), .ce_val(ce_c), .bad_addr(bad_c), .is_tlb(tlb_c)
  );

  exc_vec_sel #(.AW(AW)) u_vec (
    .kind(req_kind), .exl(st_exl), .bev(st_bev), .iv(cause_iv),
    .base(ebase), .vec(vec_c)
  );

  // next-state
  logic            boot_q, boot_d;
  logic            in_slot;
  logic            swap_ok;
  logic            rv_d, we_d, bw_d, tw_d, sw_d, cu_d;
  logic [AW-1:0]   pc_d;

  always_comb begin
    in_slot = (cur_pc + AW'(INSN_BYTES)) != cur_npc;
    swap_ok = req_valid && !st_exl && !st_bev;
    boot_d  = 1'b0;
    cu_d    = boot_q;
    we_d    = req_valid && !boot_q;
    rv_d    = boot_q || req_valid;
    bw_d    = we_d && bad_c;
    tw_d    = we_d && tlb_c;
    sw_d    = we_d && swap_ok;
    pc_d    = boot_q ? AW'(BOOT_VEC) : vec_c;
  end

  // registers: strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q      <= 1'b1;
      redir_valid <= 1'b0;
      cu1_set     <= 1'b0;
      exc_we      <= 1'b0;
      badva_we    <= 1'b0;
      tlb_we      <= 1'b0;
      srs_we      <= 1'b0;
    end else begin
      boot_q      <= boot_d;
      redir_valid <= rv_d;
      cu1_set     <= cu_d;
      exc_we      <= we_d;
      badva_we    <= bw_d;
      tlb_we      <= tw_d;
      srs_we      <= sw_d;
    end
  end

  // registers: data with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_pc  <= '0;
      redir_npc <= '0;
      exc_exl   <= 1'b0;
      exc_code  <= '0;
      bd        <= 1'b0;
      ce        <= '0;
      epc       <= '0;
      badva     <= '0;
      vpn2      <= '0;
      srs_pss   <= '0;
      srs_css   <= '0;
    end else begin
      if (rv_d) begin
        redir_pc  <= pc_d;
        redir_npc <= pc_d + AW'(INSN_BYTES);
      end
      if (we_d) begin
        exc_exl  <= 1'b1;
        exc_code <= code_c;
        bd       <= in_slot;
        ce       <= ce_c;
        epc      <= in_slot ? cur_pc - AW'(INSN_BYTES) : cur_pc;
      end
      if (bw_d) badva <= req_vaddr;
      if (tw_d) vpn2  <= req_vaddr[AW-1:VPN_LSB];
      if (sw_d) begin
        srs_pss <= srs_cur;
        srs_css <= srs_exc;
      end
    end
  end

  // R6
  pair_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (redir_npc == redir_pc + AW'(INSN_BYTES)));

  // R3
  commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_we |-> ($past(req_valid) && redir_valid && exc_exl));

  // R8
  swap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srs_we |-> (exc_we && !$past(st_exl) && !$past(st_bev)));

  // R9
  addr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_we |-> (badva_we && exc_we));

  // R7
  ce_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_we && exc_code != 5'h0B) |-> (ce == '0));

  // R4
  epc_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_we && !bd) |-> (epc == $past(cur_pc)));

  // R1
  boot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cu1_set |=> !cu1_set);
endmodule

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_store, st_exl, st_bev, cause_iv;
  logic [3:0] req_kind;
  logic [31:0] req_vaddr, cur_pc, cur_npc, ebase;
  logic [1:0] req_cop;
  logic [3:0] srs_cur, srs_exc;
  logic redir_valid, cu1_set, exc_we, exc_exl, bd, badva_we, tlb_we, srs_we;
  logic [31:0] redir_pc, redir_npc, epc, badva;
  logic [4:0] exc_code;
  logic [1:0] ce;
  logic [18:0] vpn2;
  logic [3:0] srs_pss, srs_css;

  int total = 0, bad = 0;

  exc_entry_ctrl u0 (.*);

  typedef struct packed {
    logic [3:0] kind; logic st; logic exl; logic bev; logic iv;
    logic [31:0] pc; logic [31:0] npc; logic [4:0] code; logic [31:0] vec;
  } vec_t;

  localparam int N = 14;
  localparam vec_t TBL [N] = '{
    '{4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h1004, 5'h00, 32'h8000_0180},
    '{4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 32'h1000, 32'h1004, 5'h00, 32'h8000_0200},
    '{4'd2,  1'b0, 1'b0, 1'b0, 1'b0, 32'h1100, 32'h1104, 5'h02, 32'h8000_0000},
    '{4'd2,  1'b1, 1'b1, 1'b0, 1'b0, 32'h1100, 32'h1104, 5'h03, 32'h8000_0180},
    '{4'd4,  1'b1, 1'b0, 1'b0, 1'b0, 32'h2000, 32'h3000, 5'h05, 32'h8000_0180},
    '{4'd4,  1'b0, 1'b0, 1'b0, 1'b0, 32'h2000, 32'h2004, 5'h04, 32'h8000_0180},
    '{4'd9,  1'b0, 1'b0, 1'b1, 1'b0, 32'h2200, 32'h2204, 5'h0C, 32'hBFC0_0200},
    '{4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 32'h2200, 32'h2100, 5'h0C, 32'h8000_0180},
    '{4'd10, 1'b0, 1'b1, 1'b0, 1'b0, 32'h2300, 32'h2304, 5'h0D, 32'h8000_0180},
    '{4'd3,  1'b0, 1'b0, 1'b0, 1'b0, 32'h2400, 32'h2404, 5'h02, 32'h8000_0180},
    '{4'd1,  1'b1, 1'b0, 1'b0, 1'b0, 32'h2500, 32'h2504, 5'h01, 32'h8000_0180},
    '{4'd5,  1'b0, 1'b0, 1'b0, 1'b0, 32'h2600, 32'h2604, 5'h08, 32'h8000_0180},
    '{4'd6,  1'b0, 1'b0, 1'b0, 1'b0, 32'h2700, 32'h2704, 5'h09, 32'h8000_0180},
    '{4'd7,  1'b0, 1'b0, 1'b0, 1'b1, 32'h2800, 32'h2804, 5'h0A, 32'h8000_0180}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive one request at negedge, sample 1 ns after the capturing edge
  task automatic fire(input logic [3:0] k, input logic s, input logic x, input logic b,
                      input logic v, input logic [31:0] pc, input logic [31:0] npc);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_store = s; st_exl = x; st_bev = b;
    cause_iv = v; cur_pc = pc; cur_npc = npc;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_store = 1'b0;
    req_vaddr = 32'hDEAD_6000; req_cop = 2'd2; cur_pc = '0; cur_npc = 32'd4;
    st_exl = 1'b0; st_bev = 1'b0; cause_iv = 1'b0; ebase = 32'h8000_0000;
    srs_cur = 4'd1; srs_exc = 4'd5;
    #23;
    // R1 reset state
    chk("R1 valid in reset", {31'd0, redir_valid}, 32'd0);
    chk("R1 we in reset", {26'd0, exc_we, srs_we, badva_we, tlb_we, cu1_set, 1'b0}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 boot valid", {31'd0, redir_valid}, 32'd1);
    chk("R1 boot cu1", {31'd0, cu1_set}, 32'd1);
    chk("R1 boot pc", redir_pc, 32'hBFC0_0000);
    chk("R1 boot npc", redir_npc, 32'hBFC0_0004);
    chk("R1 boot no commit", {31'd0, exc_we}, 32'd0);
    @(posedge clk); #1;
    chk("R1 boot single", {30'd0, redir_valid, cu1_set}, 32'd0);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < N; i++) begin
      fire(TBL[i].kind, TBL[i].st, TBL[i].exl, TBL[i].bev, TBL[i].iv, TBL[i].pc, TBL[i].npc);
      chk("R2 code", {27'd0, exc_code}, {27'd0, TBL[i].code});
      chk("R5 vector", redir_pc, TBL[i].vec);
      chk("R6 npc", redir_npc, TBL[i].vec + 32'd4);
      chk("R3 strobes", {30'd0, exc_we, redir_valid}, 32'd3);
      chk("R3 exl", {31'd0, exc_exl}, 32'd1);
      chk("R4 bd", {31'd0, bd}, {31'd0, (TBL[i].pc + 32'd4) != TBL[i].npc});
      chk("R4 epc", epc, ((TBL[i].pc + 32'd4) != TBL[i].npc) ? TBL[i].pc - 32'd4 : TBL[i].pc);
      chk("R7 ce zero", {30'd0, ce}, 32'd0);
      @(posedge clk); #1;
      chk("R3 single pulse", {30'd0, exc_we, redir_valid}, 32'd0);
    end

    // R7 coprocessor unusable
    fire(4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 32'h3000, 32'h3004);
    chk("R7 ce cop", {30'd0, ce}, 32'd2);
    chk("R2 cop code", {27'd0, exc_code}, 32'h0B);

    // R8 swap gated off (exl=1), previous swap values from table are 1/5
    srs_cur = 4'd7; srs_exc = 4'd9;
    fire(4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 32'h3100, 32'h3104);
    chk("R8 no swap exl", {31'd0, srs_we}, 32'd0);
    chk("R8 css held", {28'd0, srs_css}, 32'd5);
    fire(4'd5, 1'b0, 1'b0, 1'b1, 1'b0, 32'h3100, 32'h3104);
    chk("R8 no swap bev", {31'd0, srs_we}, 32'd0);
    chk("R8 pss held", {28'd0, srs_pss}, 32'd1);
    fire(4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 32'h3100, 32'h3104);
    chk("R8 swap", {31'd0, srs_we}, 32'd1);
    chk("R8 pss", {28'd0, srs_pss}, 32'd7);
    chk("R8 css", {28'd0, srs_css}, 32'd9);

    // R9 address capture
    req_vaddr = 32'h1234_E000;
    fire(4'd4, 1'b0, 1'b1, 1'b0, 1'b0, 32'h3200, 32'h3204);
    chk("R9 addr err we", {30'd0, badva_we, tlb_we}, 32'd2);
    chk("R9 badva", badva, 32'h1234_E000);
    req_vaddr = 32'h5555_A000;
    fire(4'd3, 1'b1, 1'b1, 1'b0, 1'b0, 32'h3200, 32'h3204);
    chk("R9 tlb we", {30'd0, badva_we, tlb_we}, 32'd3);
    chk("R9 vpn2", {13'd0, vpn2}, {13'd0, 19'(32'h5555_A000 >> 13)});
    req_vaddr = 32'h0BAD_0000;
    fire(4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 32'h3200, 32'h3204);
    chk("R9 syscall no we", {30'd0, badva_we, tlb_we}, 32'd0);
    chk("R9 badva held", badva, 32'h5555_A000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule